// File: doc/BRIEF.md
# Fractional-N Divider Register Interface with Staged Channel Update

This block is the receive side of a three-wire serial link (clock, data, latch enable) that programs the division settings of a fractional-N synthesizer. It brings the three serial lines into the system clock domain and assembles 24-bit words, most significant bit first. A word is decoded by the address held in its three lowest bits. A channel word carries the integer and fractional division values. An auxiliary word carries the modulus. A phase word carries the phase offset, which moves the output in steps of one modulus-th of a full turn.

Auxiliary and phase words are kept in shadow registers and have no immediate effect. A channel word captures the integer and fractional values and takes a snapshot of both shadows into a staging set. A pending flag is then raised. The staging set becomes the active divider setting on the next phase-detector strobe, which is a one-cycle enable in the system domain. At that commit the fractional value and the phase are limited to one below the modulus. Once the modulus is set, a single channel word is enough to retune the synthesizer.

Top module: `divctl_regif`

## Requirements
- R1: After synchronous reset the outputs are integer 0, fractional 0, modulus 2 (parameter `RST_MOD`), phase 0, and the load pulse is low.
- R2: Serial data is sampled on each rising edge of `ser_clk`, most significant bit first, and a rising edge of `ser_le` captures the last 24 bits. The address is bits [2:0]: 0 is channel, 1 is auxiliary, 2 is phase. A channel word has the integer in [23:15] and the fraction in [14:3]. Auxiliary and phase words carry their 12-bit value in [14:3].
- R3: A channel word changes no output before a strobe. The first `pfd_stb` after the capture puts the new integer and fraction on the outputs, and the outputs change only in the cycle after a strobe.
- R4: Auxiliary and phase words alone never change the outputs, even across strobes. They reach the outputs only through a later channel word and its strobe.
- R5: When several auxiliary or phase words arrive before a channel word, only the last value of each is committed.
- R6: The committed fraction is limited to modulus−1 when it is not below the modulus. It is 0 when the modulus is 0.
- R7: The committed phase follows the same limit: modulus−1 when it is not below the modulus, and 0 for a modulus of 0.
- R8: Words with addresses 3 to 7 change neither the outputs nor the shadow registers.
- R9: `div_load` pulses for exactly one cycle, in the cycle the outputs take a new setting. A strobe with no channel word pending does nothing.
- R10: The shadows are sampled when the channel word is captured. A later channel word before the strobe replaces the staged set, and a shadow write made after the last channel capture waits for the next channel word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; rising edge captures a word |
| pfd_stb | input | 1 | Phase-detector cycle strobe, one system clock wide |
| div_int | output | 9 | Active integer division value |
| div_frac | output | 12 | Active fractional numerator |
| div_mod | output | 12 | Active modulus |
| div_phase | output | 12 | Active phase offset |
| div_load | output | 1 | One-cycle pulse when the active setting changes |

## Verification
The bench checks that the outputs stay put after a channel word until a strobe arrives. A design that applies the word at latch time would change them early. It sends several modulus and phase words with strobes in between. Leaking shadows would show up at once, and a first-write-wins buffer would commit stale values. It overwrites the staged channel and writes the modulus again after the last capture. A design that samples the shadows at strobe time would commit a modulus that was never staged. It also sends fractions and phases at or above the modulus, a modulus of zero, and words with the five unused addresses. An unlimited comparator, a divide-by-zero path or a loose address decode would each show on the outputs.

// File: rtl/divctl_pkg.sv
package divctl_pkg;

    localparam int INT_W  = 9;
    localparam int FRAC_W = 12;
    localparam int ADDR_W = 3;
    localparam int WORD_W = INT_W + FRAC_W + ADDR_W;

    localparam int FLD_LO   = ADDR_W;
    localparam int FLD_HI   = ADDR_W + FRAC_W - 1;
    localparam int INT_LO   = ADDR_W + FRAC_W;

    typedef logic [INT_W-1:0]  int_t;
    typedef logic [FRAC_W-1:0] frac_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam addr_t ADDR_CHAN  = addr_t'(0);
    localparam addr_t ADDR_AUX   = addr_t'(1);
    localparam addr_t ADDR_PHASE = addr_t'(2);

    typedef struct packed {
        int_t  nint;
        frac_t frac;
        frac_t modulus;
        frac_t phase;
    } div_cfg_t;

    function automatic frac_t limit_to_mod(frac_t v, frac_t m);
        if (m == '0)
            return '0;
        else if (v >= m)
            return m - frac_t'(1);
        else
            return v;
    endfunction

endpackage

// File: rtl/divctl_sync.sv
module divctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/divctl_shift.sv
module divctl_shift
    import divctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sck,
    input  logic  sdi,
    input  logic  sle,
    output logic  word_vld,
    output word_t word
);
    logic  sck_q, sle_q;
    word_t shreg;
    logic  sck_rise, sle_rise;

    assign sck_rise = sck & ~sck_q;
    assign sle_rise = sle & ~sle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            sle_q    <= 1'b0;
            shreg    <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            sck_q    <= sck;
            sle_q    <= sle;
            word_vld <= sle_rise;
            if (sck_rise)
                shreg <= {shreg[WORD_W-2:0], sdi};
            if (sle_rise)
                word <= shreg;
        end
    end
endmodule

// File: rtl/divctl_bank.sv
module divctl_bank
    import divctl_pkg::*;
#(
    parameter int RST_MOD = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     word_vld,
    input  word_t    word,
    input  logic     pfd_stb,
    output div_cfg_t active,
    output logic     load
);
    localparam frac_t MOD_INIT = frac_t'(RST_MOD);

    frac_t    aux_shadow, ph_shadow;
    div_cfg_t staged;
    logic     pending;

    addr_t addr;
    frac_t field;
    int_t  int_field;
    logic  chan_hit;

    assign addr      = word[ADDR_W-1:0];
    assign field     = word[FLD_HI:FLD_LO];
    assign int_field = word[WORD_W-1:INT_LO];
    assign chan_hit  = word_vld && (addr == ADDR_CHAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            aux_shadow     <= MOD_INIT;
            ph_shadow      <= '0;
            staged         <= '{nint: '0, frac: '0, modulus: MOD_INIT, phase: '0};
            active         <= '{nint: '0, frac: '0, modulus: MOD_INIT, phase: '0};
            pending        <= 1'b0;
            load           <= 1'b0;
        end else begin
            load <= 1'b0;
            if (word_vld) begin
                case (addr)
                    ADDR_AUX:   aux_shadow <= field;
                    ADDR_PHASE: ph_shadow  <= field;
                    ADDR_CHAN: begin
                        staged.nint    <= int_field;
                        staged.frac    <= field;
                        staged.modulus <= aux_shadow;
                        staged.phase   <= ph_shadow;
                        pending        <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (pfd_stb && pending && !chan_hit) begin
                active.nint    <= staged.nint;
                active.modulus <= staged.modulus;
                active.frac    <= limit_to_mod(staged.frac, staged.modulus);
                active.phase   <= limit_to_mod(staged.phase, staged.modulus);
                pending        <= 1'b0;
                load           <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/divctl_regif.sv
module divctl_regif
    import divctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RST_MOD     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_le,
    input  logic              pfd_stb,
    output logic [INT_W-1:0]  div_int,
    output logic [FRAC_W-1:0] div_frac,
    output logic [FRAC_W-1:0] div_mod,
    output logic [FRAC_W-1:0] div_phase,
    output logic              div_load
);
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] raw_lines, sync_lines;
    logic               word_vld;
    word_t              word;
    div_cfg_t           active;

    assign raw_lines = {ser_le, ser_dat, ser_clk};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        divctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
        );
    end

    divctl_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .sck      (sync_lines[0]),
        .sdi      (sync_lines[1]),
        .sle      (sync_lines[2]),
        .word_vld (word_vld),
        .word     (word)
    );

    divctl_bank #(.RST_MOD(RST_MOD)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld),
        .word     (word),
        .pfd_stb  (pfd_stb),
        .active   (active),
        .load     (div_load)
    );

    assign div_int   = active.nint;
    assign div_frac  = active.frac;
    assign div_mod   = active.modulus;
    assign div_phase = active.phase;
endmodule

// File: rtl/divctl_regif_chk.sv
module divctl_regif_chk
    import divctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pfd_stb,
    input logic [INT_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic [FRAC_W-1:0] div_mod,
    input logic [FRAC_W-1:0] div_phase,
    input logic              div_load
);
    a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !pfd_stb |=> ($stable(div_int) && $stable(div_frac) && $stable(div_mod) && $stable(div_phase)));

    a_r9_load_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        div_load |-> $past(pfd_stb));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        div_load |=> !div_load);

    a_r6_frac_below_mod: assert property (@(posedge clk) disable iff (rst)
        (div_mod != '0) |-> (div_frac < div_mod));

    a_r6_frac_zero_mod: assert property (@(posedge clk) disable iff (rst)
        (div_mod == '0) |-> (div_frac == '0));

    a_r7_phase_below_mod: assert property (@(posedge clk) disable iff (rst)
        (div_mod != '0) |-> (div_phase < div_mod));

    a_r7_phase_zero_mod: assert property (@(posedge clk) disable iff (rst)
        (div_mod == '0) |-> (div_phase == '0));
endmodule

bind divctl_regif divctl_regif_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pfd_stb   (pfd_stb),
    .div_int   (div_int),
    .div_frac  (div_frac),
    .div_mod   (div_mod),
    .div_phase (div_phase),
    .div_load  (div_load)
);

// File: tb/divctl_regif_tb.sv
module divctl_regif_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, pfd_stb = 1'b0;
    logic [8:0]  div_int;
    logic [11:0] div_frac, div_mod, div_phase;
    logic        div_load;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    divctl_regif u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .pfd_stb(pfd_stb), .div_int(div_int), .div_frac(div_frac), .div_mod(div_mod),
        .div_phase(div_phase), .div_load(div_load)
    );

    function automatic logic [23:0] w_chan(int i, int f);
        return {i[8:0], f[11:0], 3'd0};
    endfunction
    function automatic logic [23:0] w_aux(int m);
        return {9'd0, m[11:0], 3'd1};
    endfunction
    function automatic logic [23:0] w_ph(int p);
        return {9'd0, p[11:0], 3'd2};
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(string tag, int i, int f, int m, int p);
        chk({tag, " int"},   int'(div_int),   i);
        chk({tag, " frac"},  int'(div_frac),  f);
        chk({tag, " mod"},   int'(div_mod),   m);
        chk({tag, " phase"}, int'(div_phase), p);
    endtask

    task automatic send_word(logic [23:0] w);
        for (int b = 23; b >= 0; b--) begin
            @(negedge clk); ser_dat = w[b]; ser_clk = 1'b0;
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        ser_le = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // one-cycle strobe; returns at the negedge where the update is visible
    task automatic strobe();
        @(negedge clk); pfd_stb = 1'b1;
        @(negedge clk); pfd_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk_out("R1 reset", 0, 0, 2, 0);
        chk("R1 reset load", int'(div_load), 0);
    endtask

    task automatic t_channel();
        send_word(w_aux(65));
        send_word(w_chan(144, 40));
        chk_out("R3 before strobe", 0, 0, 2, 0);
        strobe();
        chk_out("R2 R3 after strobe", 144, 40, 65, 0);
        chk("R9 load pulse", int'(div_load), 1);
        @(negedge clk);
        chk("R9 load one cycle", int'(div_load), 0);
    endtask

    task automatic t_shadow_hold();
        send_word(w_ph(26));
        strobe();
        chk("R9 idle strobe no load", int'(div_load), 0);
        strobe();
        chk_out("R4 phase held", 144, 40, 65, 0);
        send_word(w_aux(100));
        strobe();
        chk_out("R4 aux held", 144, 40, 65, 0);
        send_word(w_chan(144, 41));
        strobe();
        chk_out("R4 committed by channel", 144, 41, 100, 26);
    endtask

    task automatic t_last_wins();
        send_word(w_ph(5));
        send_word(w_ph(7));
        send_word(w_aux(50));
        send_word(w_aux(80));
        send_word(w_chan(10, 3));
        strobe();
        chk_out("R5 last write", 10, 3, 80, 7);
    endtask

    task automatic t_clamp();
        send_word(w_aux(20));
        send_word(w_chan(1, 25));
        strobe();
        chk("R6 frac limited", int'(div_frac), 19);
        send_word(w_ph(30));
        send_word(w_chan(1, 5));
        strobe();
        chk("R7 phase limited", int'(div_phase), 19);
        chk("R7 frac in range", int'(div_frac), 5);
        send_word(w_aux(0));
        send_word(w_ph(9));
        send_word(w_chan(2, 9));
        strobe();
        chk_out("R6 R7 zero modulus", 2, 0, 0, 0);
    endtask

    task automatic t_unused();
        send_word(w_aux(64));
        send_word(w_ph(1));
        send_word(w_chan(3, 4));
        strobe();
        chk_out("R8 baseline", 3, 4, 64, 1);
        for (int a = 3; a < 8; a++) begin
            send_word({9'h1FF, 12'hABC, a[2:0]});
        end
        strobe();
        chk_out("R8 outputs untouched", 3, 4, 64, 1);
        send_word(w_chan(3, 5));
        strobe();
        chk_out("R8 shadows untouched", 3, 5, 64, 1);
    endtask

    task automatic t_overwrite();
        send_word(w_chan(7, 1));
        send_word(w_aux(90));
        send_word(w_chan(8, 2));
        send_word(w_aux(33));
        strobe();
        chk_out("R10 staged replaced", 8, 2, 90, 1);
        send_word(w_chan(8, 3));
        strobe();
        chk_out("R10 late aux next", 8, 3, 33, 1);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_channel();
        t_shadow_hold();
        t_last_wins();
        t_clamp();
        t_unused();
        t_overwrite();
        done = 1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end
endmodule